// File: doc/BRIEF.md
# Chromosome-Configured Function-Element Array

This block is a grid of small processing elements laid out in columns, with every element's operation and operand wiring taken from one binary configuration word, the chromosome. Each element reads two operands. In the first column, the operands come from the primary input lanes. In every later column, they come only from the outputs of the column directly before it. Because routing is limited to the neighbouring column, the chromosome stays short. A search engine outside the block can therefore write a candidate configuration and read back the circuit's response quickly.

The parameter `MODE` selects one of two variants. In gate-level mode, every lane is a single wire and the elements are logic gates. In function-level mode, every lane is a `BUS_W`-bit unsigned bus and the elements compute the truncated mean, the larger operand or the smaller operand. The chromosome is shifted in one bit per clock into a shadow register. A commit strobe copies the whole word into the working register in one step, so the array never runs on a partly written configuration.

Each column is registered. A valid flag travels with the data, so results emerge a fixed number of cycles after their input. The array accepts a new input vector on every clock.

Top module: `fe_grid`

## Requirements
- R1: After reset, `out_valid` is low, `out_data` is zero and the working configuration is all zeros. In that state each element applies code 0 to operand index 0 on both inputs, and every output selects row 0.
- R2: While `cfg_load` is high, `cfg_bit` is shifted into a shadow register once per clock. The first bit sent ends up at chromosome bit 0 after `CL` bits. The working configuration, and with it the datapath, changes only on a `cfg_commit` clock, when it takes the shadow contents.
- R3: The gene of the element at column c, row r starts at bit (c*N_ROWS+r)*EG. It holds the function code in its low FW bits, then operand-A select (SW bits), then operand-B select (SW bits). FW is 3 in gate mode and 2 in function mode, SW is ceil(log2(max(N_IN,N_ROWS))), and EG=FW+2*SW. The select for output k starts at bit N_COLS*N_ROWS*EG + k*OSW, with OSW=ceil(log2(N_ROWS)) (at least 1).
- R4: In gate-level mode, codes 0 to 5 give AND, OR, XOR, NAND, NOR and XNOR of the two operand bits.
- R5: In function-level mode, with unsigned operands, code 0 gives floor((a+b)/2) computed without losing the carry, code 1 gives the larger operand and code 2 gives the smaller.
- R6: A code outside the defined set (6 and 7 in gate mode, 3 in function mode) passes operand A through unchanged.
- R7: Operand selects in column 0 index input lanes, where lane i is `in_data[i*DW +: DW]`. Selects in later columns index rows of the previous column. A select at or beyond the number of sources picks source 0.
- R8: Output k, `out_data[k*DW +: DW]`, is the last-column row named by its output select. A select at or beyond N_ROWS picks row 0.
- R9: A vector presented with `in_valid` is reflected on `out_valid` and `out_data` exactly N_COLS clocks later and not before, and a new vector is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Shift enable for the shadow chromosome |
| cfg_bit | input | 1 | Serial chromosome bit |
| cfg_commit | input | 1 | Copies the shadow chromosome into the working one |
| in_valid | input | 1 | Input vector qualifier |
| in_data | input | N_IN*DW | Primary input lanes |
| out_valid | output | 1 | Output vector qualifier |
| out_data | output | N_OUT*DW | Selected last-column results |

## Verification
The mean of two all-ones buses is a key case. A design that drops the carry returns half the true value instead of all ones. Out-of-range operand and output selects are driven on purpose: a design that indexes past the end would return zero or stale data where row or lane 0 is required. Shifting a new chromosome in without a commit must leave the results untouched, which exposes any design that uses the shadow word directly. The latency is probed one cycle early to catch an extra or missing pipeline stage. Random chromosomes streamed back to back then exercise every code and routing choice against a bench model of the gene layout.

// File: rtl/fe_pkg.sv
package fe_pkg;

   localparam int MODE_GATE = 0;
   localparam int MODE_FUNC = 1;

   localparam int GATE_FW = 3;
   localparam int FUNC_FW = 2;

   typedef enum logic [2:0] {
      OP_AND  = 3'd0,
      OP_OR   = 3'd1,
      OP_XOR  = 3'd2,
      OP_NAND = 3'd3,
      OP_NOR  = 3'd4,
      OP_XNOR = 3'd5
   } gate_op_e;

   typedef enum logic [1:0] {
      OP_MEAN = 2'd0,
      OP_MAX  = 2'd1,
      OP_MIN  = 2'd2
   } func_op_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fe_cfg.sv
module fe_cfg #(
   parameter int CL = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_en,
   input  logic          load_bit,
   input  logic          commit,
   output logic [CL-1:0] active
);

   logic [CL-1:0] shadow;

   generate
      if (CL > 1) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       shadow <= '0;
            else if (load_en) shadow <= {load_bit, shadow[CL-1:1]};
         end
      end else begin : g_narrow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       shadow <= '0;
            else if (load_en) shadow <= load_bit;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active <= '0;
      else if (commit) active <= shadow;
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active)); // R2
   AST_CFG_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (active == $past(shadow))); // R2

endmodule

// File: rtl/fe_cell.sv
module fe_cell
   import fe_pkg::*;
#(
   parameter int MODE = MODE_GATE,
   parameter int DW   = 1
) (
   input  logic [((MODE == MODE_FUNC) ? FUNC_FW : GATE_FW)-1:0] fsel,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);

   generate
      if (MODE == MODE_GATE) begin : g_gate
         always_comb begin
            case (fsel)
               OP_AND:  y = a & b;
               OP_OR:   y = a | b;
               OP_XOR:  y = a ^ b;
               OP_NAND: y = ~(a & b);
               OP_NOR:  y = ~(a | b);
               OP_XNOR: y = ~(a ^ b);
               default: y = a;
            endcase
         end
      end else begin : g_func
         logic [DW:0] sum;
         assign sum = {1'b0, a} + {1'b0, b};
         always_comb begin
            case (fsel)
               OP_MEAN: y = sum[DW:1];
               OP_MAX:  y = (a > b) ? a : b;
               OP_MIN:  y = (a < b) ? a : b;
               default: y = a;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/fe_column.sv
module fe_column
   import fe_pkg::*;
#(
   parameter int MODE   = MODE_GATE,
   parameter int DW     = 1,
   parameter int SW     = 2,
   parameter int N_SRC  = 4,
   parameter int N_ROWS = 4,
   localparam int FW    = (MODE == MODE_FUNC) ? FUNC_FW : GATE_FW,
   localparam int EG    = FW + 2 * SW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 src_vld,
   input  logic [N_SRC*DW-1:0]  src,
   input  logic [N_ROWS*EG-1:0] genes,
   output logic                 col_vld,
   output logic [N_ROWS*DW-1:0] col
);

   logic [N_ROWS*DW-1:0] nxt;

   generate
      for (genvar r = 0; r < N_ROWS; r++) begin : g_row
         logic [EG-1:0] g;
         logic [FW-1:0] fsel;
         logic [SW-1:0] sa, sb;
         logic [DW-1:0] opa, opb, res;

         assign g    = genes[r*EG +: EG];
         assign fsel = g[FW-1:0];
         assign sa   = g[FW +: SW];
         assign sb   = g[FW+SW +: SW];

         always_comb begin
            opa = src[0 +: DW];
            opb = src[0 +: DW];
            for (int i = 1; i < N_SRC; i++) begin
               if (sa == SW'(i)) opa = src[i*DW +: DW];
               if (sb == SW'(i)) opb = src[i*DW +: DW];
            end
         end

         fe_cell #(.MODE(MODE), .DW(DW)) u_cell (
            .fsel (fsel),
            .a    (opa),
            .b    (opb),
            .y    (res)
         );

         assign nxt[r*DW +: DW] = res;

         if (MODE == MODE_FUNC) begin : g_chk
            AST_MEAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
               (fsel == FW'(OP_MEAN)) |-> ((res >= opa || res >= opb) &&
                                          (res <= opa || res <= opb))); // R5
            AST_MAX_PICK: assert property (@(posedge clk) disable iff (!rst_n)
               (fsel == FW'(OP_MAX)) |-> ((res == opa || res == opb) &&
                                         res >= opa && res >= opb)); // R5
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col     <= '0;
         col_vld <= 1'b0;
      end else begin
         col     <= nxt;
         col_vld <= src_vld;
      end
   end

   AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      src_vld |=> col_vld); // R9
   AST_VLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !src_vld |=> !col_vld); // R9

endmodule

// File: rtl/fe_grid.sv
module fe_grid
   import fe_pkg::*;
#(
   parameter int MODE   = MODE_GATE,
   parameter int N_IN   = 4,
   parameter int N_ROWS = 4,
   parameter int N_COLS = 3,
   parameter int N_OUT  = 2,
   parameter int BUS_W  = 8,
   localparam int DW    = (MODE == MODE_FUNC) ? BUS_W : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_load,
   input  logic                cfg_bit,
   input  logic                cfg_commit,
   input  logic                in_valid,
   input  logic [N_IN*DW-1:0]  in_data,
   output logic                out_valid,
   output logic [N_OUT*DW-1:0] out_data
);

   localparam int FW  = (MODE == MODE_FUNC) ? FUNC_FW : GATE_FW;
   localparam int SW  = idx_w((N_IN > N_ROWS) ? N_IN : N_ROWS);
   localparam int EG  = FW + 2 * SW;
   localparam int CG  = N_ROWS * EG;
   localparam int NE  = N_COLS * N_ROWS;
   localparam int OSW = idx_w(N_ROWS);
   localparam int CL  = NE * EG + N_OUT * OSW;

   generate
      if (MODE != MODE_GATE && MODE != MODE_FUNC) begin : g_bad_mode
         $error("fe_grid: MODE must be 0 or 1");
      end
      if (N_IN < 1 || N_ROWS < 1 || N_COLS < 1 || N_OUT < 1) begin : g_bad_size
         $error("fe_grid: every count must be at least 1");
      end
      if (MODE == MODE_FUNC && BUS_W < 2) begin : g_bad_bus
         $error("fe_grid: BUS_W must be at least 2 in function mode");
      end
   endgenerate

   logic [CL-1:0] active;

   fe_cfg #(.CL(CL)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (cfg_load),
      .load_bit (cfg_bit),
      .commit   (cfg_commit),
      .active   (active)
   );

   logic [N_ROWS*DW-1:0] cdat [N_COLS];
   logic                 cvld [N_COLS];

   generate
      for (genvar c = 0; c < N_COLS; c++) begin : g_col
         if (c == 0) begin : g_first
            fe_column #(
               .MODE(MODE), .DW(DW), .SW(SW), .N_SRC(N_IN), .N_ROWS(N_ROWS)
            ) u_col (
               .clk     (clk),
               .rst_n   (rst_n),
               .src_vld (in_valid),
               .src     (in_data),
               .genes   (active[0 +: CG]),
               .col_vld (cvld[c]),
               .col     (cdat[c])
            );
         end else begin : g_next
            fe_column #(
               .MODE(MODE), .DW(DW), .SW(SW), .N_SRC(N_ROWS), .N_ROWS(N_ROWS)
            ) u_col (
               .clk     (clk),
               .rst_n   (rst_n),
               .src_vld (cvld[c-1]),
               .src     (cdat[c-1]),
               .genes   (active[c*CG +: CG]),
               .col_vld (cvld[c]),
               .col     (cdat[c])
            );
         end
      end

      for (genvar k = 0; k < N_OUT; k++) begin : g_out
         logic [OSW-1:0] osel;
         logic [DW-1:0]  pick;

         assign osel = active[NE*EG + k*OSW +: OSW];

         always_comb begin
            pick = cdat[N_COLS-1][0 +: DW];
            for (int i = 1; i < N_ROWS; i++) begin
               if (osel == OSW'(i)) pick = cdat[N_COLS-1][i*DW +: DW];
            end
         end

         assign out_data[k*DW +: DW] = pick;
      end
   endgenerate

   assign out_valid = cvld[N_COLS-1];

endmodule

// File: tb/test_fe_grid.sv
`timescale 1ns/1ps
module test_fe_grid;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        g_load = 0, g_bit = 0, g_commit = 0, g_vld = 0;
   logic [3:0]  g_in = '0;
   logic        g_ovld;
   logic [1:0]  g_out;

   logic        f_load = 0, f_bit = 0, f_commit = 0, f_vld = 0;
   logic [23:0] f_in = '0;
   logic        f_ovld;
   logic [15:0] f_out;

   int n_cmp = 0;
   int n_bad = 0;

   fe_grid #(.MODE(0), .N_IN(4), .N_ROWS(4), .N_COLS(3), .N_OUT(2)) i_fe_grid (
      .clk(clk), .rst_n(rst_n), .cfg_load(g_load), .cfg_bit(g_bit),
      .cfg_commit(g_commit), .in_valid(g_vld), .in_data(g_in),
      .out_valid(g_ovld), .out_data(g_out)
   );

   fe_grid #(.MODE(1), .N_IN(3), .N_ROWS(3), .N_COLS(2), .N_OUT(2), .BUS_W(8)) i_fe_grid_fn (
      .clk(clk), .rst_n(rst_n), .cfg_load(f_load), .cfg_bit(f_bit),
      .cfg_commit(f_commit), .in_valid(f_vld), .in_data(f_in),
      .out_valid(f_ovld), .out_data(f_out)
   );

   function automatic int iw(int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic logic [31:0] model(int mode, int nin, int nr, int nc, int no, int w,
                                         logic [127:0] cfg, logic [31:0] inp);
      int dw, fw, sw, eg, ne, osw, nsrc, dm;
      int prev [8];
      int cur [8];
      logic [31:0] res;
      dw = mode ? w : 1;
      fw = mode ? 2 : 3;
      sw = iw((nin > nr) ? nin : nr);
      eg = fw + 2 * sw;
      ne = nc * nr;
      osw = iw(nr);
      dm = (1 << dw) - 1;
      for (int i = 0; i < 8; i++) begin prev[i] = 0; cur[i] = 0; end
      for (int i = 0; i < nin; i++) prev[i] = int'(inp >> (i * dw)) & dm;
      nsrc = nin;
      for (int c = 0; c < nc; c++) begin
         for (int r = 0; r < nr; r++) begin
            logic [127:0] g;
            int f, sa, sb, a, b, x;
            g  = cfg >> ((c * nr + r) * eg);
            f  = int'(g) & ((1 << fw) - 1);
            sa = int'(g >> fw) & ((1 << sw) - 1);
            sb = int'(g >> (fw + sw)) & ((1 << sw) - 1);
            a  = (sa < nsrc) ? prev[sa] : prev[0];
            b  = (sb < nsrc) ? prev[sb] : prev[0];
            if (mode == 0) begin
               case (f)
                  0: x = a & b;
                  1: x = a | b;
                  2: x = a ^ b;
                  3: x = ~(a & b);
                  4: x = ~(a | b);
                  5: x = ~(a ^ b);
                  default: x = a;
               endcase
            end else begin
               case (f)
                  0: x = (a + b) >> 1;
                  1: x = (a > b) ? a : b;
                  2: x = (a < b) ? a : b;
                  default: x = a;
               endcase
            end
            cur[r] = x & dm;
         end
         for (int r = 0; r < nr; r++) prev[r] = cur[r];
         nsrc = nr;
      end
      res = '0;
      for (int k = 0; k < no; k++) begin
         int s, v;
         s = int'(cfg >> (ne * eg + k * osw)) & ((1 << osw) - 1);
         v = (s < nr) ? prev[s] : prev[0];
         res = res | (32'(v) << (k * dw));
      end
      return res;
   endfunction

   function automatic logic [31:0] expect_of(bit fn, logic [127:0] cfg, logic [31:0] inp);
      return fn ? model(1, 3, 3, 2, 2, 8, cfg, inp) : model(0, 4, 4, 3, 2, 1, cfg, inp);
   endfunction

   function automatic logic [127:0] put(logic [127:0] cfg, int pos, int width, int val);
      logic [127:0] c;
      c = cfg;
      for (int i = 0; i < width; i++) c[pos + i] = val[i];
      return c;
   endfunction

   function automatic int cfg_len(bit fn);
      return fn ? 40 : 88;
   endfunction

   function automatic int lat(bit fn);
      return fn ? 2 : 3;
   endfunction

   function automatic logic [31:0] out_d(bit fn);
      return fn ? {16'b0, f_out} : {30'b0, g_out};
   endfunction

   function automatic logic out_v(bit fn);
      return fn ? f_ovld : g_ovld;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(bit fn, logic [31:0] inp, bit v);
      if (fn) begin f_vld = v; f_in = inp[23:0]; end
      else    begin g_vld = v; g_in = inp[3:0];  end
   endtask

   task automatic shift_cfg(bit fn, logic [127:0] cfg);
      for (int i = 0; i < cfg_len(fn); i++) begin
         if (fn) begin f_load = 1; f_bit = cfg[i]; end
         else    begin g_load = 1; g_bit = cfg[i]; end
         @(negedge clk);
      end
      f_load = 0; g_load = 0;
   endtask

   task automatic do_commit(bit fn);
      if (fn) f_commit = 1; else g_commit = 1;
      @(negedge clk);
      f_commit = 0; g_commit = 0;
   endtask

   task automatic load(bit fn, logic [127:0] cfg);
      shift_cfg(fn, cfg);
      do_commit(fn);
   endtask

   task automatic single(bit fn, logic [31:0] inp, logic [31:0] exp, string req);
      drive(fn, inp, 1);
      @(negedge clk);
      drive(fn, 0, 0);
      repeat (lat(fn) - 2) @(negedge clk);
      chk("R9 early valid", {31'b0, out_v(fn)}, 32'd0);
      @(negedge clk);
      chk("R9 valid", {31'b0, out_v(fn)}, 32'd1);
      chk(req, out_d(fn), exp);
   endtask

   task automatic stream(bit fn, logic [127:0] cfg, int count);
      logic [31:0] ex [32];
      for (int i = 0; i < count + lat(fn); i++) begin
         if (i >= lat(fn)) begin
            chk("R9 stream valid", {31'b0, out_v(fn)}, 32'd1);
            chk("R3 R4 R5 R7 R8 stream data", out_d(fn), ex[i - lat(fn)]);
         end
         if (i < count) begin
            logic [31:0] v;
            v = $urandom & (fn ? 32'h00FF_FFFF : 32'h0000_000F);
            ex[i] = expect_of(fn, cfg, v);
            drive(fn, v, 1);
         end else begin
            drive(fn, 0, 0);
         end
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [127:0] cfg, rnd;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 gate valid", {31'b0, g_ovld}, 32'd0);
      chk("R1 gate data", {30'b0, g_out}, 32'd0);
      chk("R1 fn valid", {31'b0, f_ovld}, 32'd0);
      chk("R1 fn data", {16'b0, f_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: all-zero configuration copies lane 0 to every output
      single(0, 32'h1, 32'h3, "R1 zero config gate");
      single(0, 32'hE, 32'h0, "R1 zero config gate");
      single(1, 32'h11225A, 32'h5A5A, "R1 zero config fn");

      // R4 R3: gate codes on element col0 row0, operands lanes 0 and 1
      cfg = put('0, 0, 3, 2); cfg = put(cfg, 5, 2, 1);
      load(0, cfg);
      single(0, 32'h3, 32'h0, "R4 XOR 1^1");
      single(0, 32'h1, 32'h3, "R4 XOR 1^0");
      cfg = put(cfg, 0, 3, 3);
      load(0, cfg);
      single(0, 32'h3, 32'h0, "R4 NAND 1,1");
      single(0, 32'h2, 32'h3, "R4 NAND 0,1");
      // R6: undefined gate code passes operand A (lane 2)
      cfg = put('0, 0, 3, 6); cfg = put(cfg, 3, 2, 2);
      load(0, cfg);
      single(0, 32'h4, 32'h3, "R6 gate pass");
      single(0, 32'hB, 32'h0, "R6 gate pass");
      // R8: last column row 1 = NOR(row0,row0), output 1 selects row 1
      cfg = put('0, 9 * 7, 3, 4); cfg = put(cfg, 86, 2, 1);
      load(0, cfg);
      single(0, 32'h1, 32'h1, "R8 output select gate");
      single(0, 32'h0, 32'h2, "R8 output select gate");

      // R5: function codes on col0 row0, operands lanes 0 and 1; output 1 select 3 is out of range
      cfg = put('0, 4, 2, 1); cfg = put(cfg, 38, 2, 3);
      load(1, cfg);
      single(1, 32'h00FFFF, 32'hFFFF, "R5 mean 255,255 R8");
      single(1, 32'h0000FF, 32'h7F7F, "R5 mean 255,0");
      cfg = put(cfg, 0, 2, 1);
      load(1, cfg);
      single(1, 32'h00F010, 32'hF0F0, "R5 max");
      cfg = put(cfg, 0, 2, 2);
      load(1, cfg);
      single(1, 32'h00F010, 32'h1010, "R5 min");
      cfg = put(cfg, 0, 2, 3);
      load(1, cfg);
      single(1, 32'h0010F0, 32'hF0F0, "R6 fn pass");
      // R7: operand select 3 with three lanes picks lane 0
      cfg = put('0, 0, 2, 3); cfg = put(cfg, 2, 2, 3);
      load(1, cfg);
      single(1, 32'h779933, 32'h3333, "R7 out of range operand");

      // R2: shifting without commit leaves the working chromosome in place
      cfg = put('0, 0, 3, 2); cfg = put(cfg, 5, 2, 1);
      load(0, cfg);
      single(0, 32'h1, 32'h3, "R2 before shift");
      rnd = {$urandom, $urandom, $urandom, $urandom};
      shift_cfg(0, rnd);
      single(0, 32'h1, 32'h3, "R2 shadow isolated");
      single(0, 32'h2, 32'h3, "R2 shadow isolated");
      do_commit(0);
      for (int v = 0; v < 16; v++) single(0, 32'(v), expect_of(0, rnd, 32'(v)), "R2 after commit");

      // random chromosomes, streamed vectors
      for (int n = 0; n < 20; n++) begin
         rnd = {$urandom, $urandom, $urandom, $urandom};
         load(0, rnd);
         stream(0, rnd, 16);
         rnd = {$urandom, $urandom, $urandom, $urandom};
         load(1, rnd);
         stream(1, rnd, 16);
      end
      finish_run();
   end

endmodule